// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single-byte accesses from an internal access port into asynchronous NAND flash bus cycles. An access carries a window address, a direction and, for writes, one byte. The top address bits pick one of the chip enables. The low byte of the address is the offset inside that chip's window, and it decides whether a written byte goes out as a command byte, an address byte or a data byte. Reads are always data reads.

Two 32-bit timing words set how long each phase lasts, counted in controller clock ticks. The write word holds four byte fields: bits [31:24] set the setup delay after chip enable, which both directions use; bits [23:16] set the extension after a write; bits [15:8] set the write cycle length; bits [7:0] set the write-strobe high time. The read word also holds four byte fields: bits [31:24] set the access delay before the bus is sampled; bits [23:16] set the read-strobe high hold; bits [15:8] set the read-strobe low pulse; bits [7:0] set the bus-release extension. A field of zero counts as one tick.

The controller runs a state machine with eight states. IDLE goes to SETUP when an access is accepted. SETUP goes to WLOW on a write and to RLOW on a read. The write path runs WLOW → WHIGH → WEXT → IDLE. The read path runs RLOW → RHOLD → REXT → IDLE. Every transition out of a non-idle state happens when the shared phase counter reaches the length of that state. A synchronised copy of the ready/busy pin is reported in bit 31 of a status word.

Top module: `nand_cycle_gen`

## Requirements
- R1: While reset is held and just after it, every chip enable is high, both strobes are high, CLE, ALE and the bus output enable are low, acc_ready is high, rd_valid is low and status_word is zero.
- R2: acc_addr[9:8] selects the chip enable that goes low for the whole cycle. For a write, offset acc_addr[7:0] = 0x00 raises CLE, offset 0x04 raises ALE, and any other offset is a data byte with neither raised. A read never raises CLE or ALE, whatever its offset.
- R3: A write drives the byte with the output enable high for the whole cycle. WE# stays high for the setup count, then goes low for (cycle − high) ticks, or for 1 tick if cycle ≤ high. It then stays high for the high count and then for the extension count, and the block returns to idle.
- R4: A read holds RE# high for the setup count and then low for max(pulse, access) ticks. It captures the bus on the access-th tick of RE# low, holds RE# high for the hold count and then for the release count. It then presents the captured byte with rd_valid high for exactly one cycle, in the first idle cycle.
- R5: Any timing field equal to 0 lasts exactly one tick.
- R6: acc_ready is high only when no cycle is in progress. An access held valid while the block is busy is stalled and is then carried out exactly once, with no loss.
- R7: status_word[31] follows nand_rb (1 = ready) two clock edges later, and bits [30:0] read zero.
- R8: At most one chip enable is low at a time, WE# and RE# are never low together, and CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wtim | input | 32 | Write timing word (setup, write extension, cycle, high time) |
| cfg_rtim | input | 32 | Read timing word (access, hold, pulse, release) |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Block idle, request accepted this cycle |
| acc_addr | input | 10 | Chip select [9:8] and window offset [7:0] |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: read byte available |
| rd_data | output | 8 | Captured read byte |
| status_word | output | 32 | Bit 31 = synchronised ready, others zero |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | Bus byte driven on writes |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte from the flash |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench changes the input bus value every cycle, so a capture taken one tick early or late returns a different byte. The same holds for a capture taken from the wrong phase. One write sets the cycle count below the high count, which catches an underflowing low-pulse subtraction: that would stretch WE# low for hundreds of ticks. One read sets the access count longer than the pulse, which catches a design that lets RE# rise before sampling, and all-zero timing words catch a counter that treats zero as 256 ticks. A request held valid across a busy cycle must be carried out exactly once, so a design that drops it, or repeats it, shows the wrong number of write pulses or the wrong bytes on those pulses.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_WLOW,
        S_WHIGH,
        S_WEXT,
        S_RLOW,
        S_RHOLD,
        S_REXT
    } cyc_state_e;

    typedef enum logic [1:0] {
        K_CMD,
        K_ADR,
        K_DAT
    } byte_kind_e;

endpackage

// File: rtl/nand_phase_ctr.sv
module nand_phase_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] tick
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick <= ONE;
        else if (restart)
            tick <= ONE;
        else if (tick != '1)
            tick <= tick + ONE;
    end

    // R5
    tick_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick != '0);

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_in,
    output logic rb_ready
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else
            shreg <= {shreg[STAGES-2:0], rb_in};
    end

    assign rb_ready = shreg[STAGES-1];

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nand_cyc_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int WIN_W       = 8,
    parameter int FIELD_W     = 8,
    parameter int IO_W        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CS_W       = $clog2(NUM_CS),
    localparam int ADDR_W     = CS_W + WIN_W,
    localparam int TIM_W      = 4 * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  cfg_wtim,
    input  logic [TIM_W-1:0]  cfg_rtim,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [IO_W-1:0]   acc_wdata,
    output logic              rd_valid,
    output logic [IO_W-1:0]   rd_data,
    output logic [31:0]       status_word,
    output logic [NUM_CS-1:0] nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [IO_W-1:0]   nand_io_out,
    output logic              nand_io_oe,
    input  logic [IO_W-1:0]   nand_io_in,
    input  logic              nand_rb
);
    localparam logic [WIN_W-1:0] OFS_CMD = WIN_W'(0);
    localparam logic [WIN_W-1:0] OFS_ADR = WIN_W'(4);

    function automatic logic [FIELD_W-1:0] eff(input logic [FIELD_W-1:0] v);
        return (v == '0) ? FIELD_W'(1) : v;
    endfunction

    // effective phase lengths
    logic [FIELD_W-1:0] w_setup, w_ext, w_cyc, w_hi, w_low;
    logic [FIELD_W-1:0] r_acc, r_hold, r_pulse, r_rel, r_low;

    assign w_setup = eff(cfg_wtim[4*FIELD_W-1 -: FIELD_W]);
    assign w_ext   = eff(cfg_wtim[3*FIELD_W-1 -: FIELD_W]);
    assign w_cyc   = eff(cfg_wtim[2*FIELD_W-1 -: FIELD_W]);
    assign w_hi    = eff(cfg_wtim[FIELD_W-1:0]);
    assign w_low   = (w_cyc > w_hi) ? (w_cyc - w_hi) : FIELD_W'(1);

    assign r_acc   = eff(cfg_rtim[4*FIELD_W-1 -: FIELD_W]);
    assign r_hold  = eff(cfg_rtim[3*FIELD_W-1 -: FIELD_W]);
    assign r_pulse = eff(cfg_rtim[2*FIELD_W-1 -: FIELD_W]);
    assign r_rel   = eff(cfg_rtim[FIELD_W-1:0]);
    assign r_low   = (r_acc > r_pulse) ? r_acc : r_pulse;

    cyc_state_e          st, st_nx;
    logic [CS_W-1:0]     cs_q;
    byte_kind_e          kind_q;
    logic                wr_q;
    logic [IO_W-1:0]     wd_q;
    logic [IO_W-1:0]     rd_q;
    logic                rdv_q;
    logic [FIELD_W-1:0]  tick;
    logic [FIELD_W-1:0]  phase_len;
    logic                accept, adv;
    logic                ce_act, cle_o, ale_o, we_o, re_o, oe_o;
    logic                rb_ready;

    assign accept = acc_valid && (st == S_IDLE);

    always_comb begin
        unique case (st)
            S_IDLE:  phase_len = FIELD_W'(1);
            S_SETUP: phase_len = w_setup;
            S_WLOW:  phase_len = w_low;
            S_WHIGH: phase_len = w_hi;
            S_WEXT:  phase_len = w_ext;
            S_RLOW:  phase_len = r_low;
            S_RHOLD: phase_len = r_hold;
            S_REXT:  phase_len = r_rel;
        endcase
    end

    assign adv = (st != S_IDLE) && (tick == phase_len);

    nand_phase_ctr #(.CNT_W(FIELD_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept || adv),
        .tick    (tick)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (accept) st_nx = S_SETUP;
            S_SETUP: if (adv) st_nx = wr_q ? S_WLOW : S_RLOW;
            S_WLOW:  if (adv) st_nx = S_WHIGH;
            S_WHIGH: if (adv) st_nx = S_WEXT;
            S_WEXT:  if (adv) st_nx = S_IDLE;
            S_RLOW:  if (adv) st_nx = S_RHOLD;
            S_RHOLD: if (adv) st_nx = S_REXT;
            S_REXT:  if (adv) st_nx = S_IDLE;
        endcase
    end

    // state register and access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cs_q   <= '0;
            kind_q <= K_DAT;
            wr_q   <= 1'b0;
            wd_q   <= '0;
            rd_q   <= '0;
            rdv_q  <= 1'b0;
        end else begin
            st    <= st_nx;
            rdv_q <= (st == S_REXT) && adv;
            if (accept) begin
                cs_q <= acc_addr[ADDR_W-1 -: CS_W];
                wr_q <= acc_write;
                wd_q <= acc_wdata;
                if (!acc_write)
                    kind_q <= K_DAT;
                else if (acc_addr[WIN_W-1:0] == OFS_CMD)
                    kind_q <= K_CMD;
                else if (acc_addr[WIN_W-1:0] == OFS_ADR)
                    kind_q <= K_ADR;
                else
                    kind_q <= K_DAT;
            end
            if ((st == S_RLOW) && (tick == r_acc))
                rd_q <= nand_io_in;
        end
    end

    // pin outputs
    always_comb begin
        ce_act = 1'b1;
        cle_o  = (kind_q == K_CMD);
        ale_o  = (kind_q == K_ADR);
        oe_o   = wr_q;
        we_o   = 1'b1;
        re_o   = 1'b1;
        unique case (st)
            S_IDLE: begin
                ce_act = 1'b0;
                cle_o  = 1'b0;
                ale_o  = 1'b0;
                oe_o   = 1'b0;
            end
            S_WLOW:  we_o = 1'b0;
            S_RLOW:  re_o = 1'b0;
            S_SETUP, S_WHIGH, S_WEXT, S_RHOLD, S_REXT: ;
        endcase
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
        assign nand_ce_n[g] = !(ce_act && (cs_q == CS_W'(g)));
    end

    assign nand_cle    = cle_o;
    assign nand_ale    = ale_o;
    assign nand_we_n   = we_o;
    assign nand_re_n   = re_o;
    assign nand_io_oe  = oe_o;
    assign nand_io_out = wd_q;
    assign acc_ready   = (st == S_IDLE);
    assign rd_valid    = rdv_q;
    assign rd_data     = rd_q;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_in    (nand_rb),
        .rb_ready (rb_ready)
    );

    assign status_word = {rb_ready, 31'b0};

    // R8
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R8
    cle_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R6
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |-> (&nand_ce_n));
    // R4
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R3
    we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_io_oe);
    // R4
    re_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

endmodule

// File: tb/tb_nand_cycle_gen.sv
module tb_nand_cycle_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_wtim = '0;
    logic [31:0] cfg_rtim = '0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic [9:0]  acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [31:0] status_word;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = '0;
    logic        nand_rb = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    nand_cycle_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_wtim(cfg_wtim), .cfg_rtim(cfg_rtim),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .status_word(status_word), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int eff(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    // one access; measures the strobe waveform until the block is idle again
    task automatic do_access(input logic wr, input logic [9:0] addr, input logic [7:0] wd,
                             input logic [31:0] wt, input logic [31:0] rt,
                             output int busy, output int setup, output int lowlen,
                             output logic cle_s, output logic ale_s, output logic [3:0] ce_s,
                             output logic [7:0] io_s, output logic oe_s,
                             output logic rv, output logic [7:0] rd);
        logic started;
        @(negedge clk);
        cfg_wtim = wt; cfg_rtim = rt;
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        busy = 0; setup = -1; lowlen = 0; started = 1'b0;
        cle_s = 0; ale_s = 0; ce_s = '1; io_s = 0; oe_s = 0;
        while (!acc_ready && busy < 3000) begin
            nand_io_in = 8'(8'h40 + busy);
            if (!(wr ? nand_we_n : nand_re_n)) begin
                if (!started) begin
                    started = 1'b1;
                    setup = busy;
                    cle_s = nand_cle; ale_s = nand_ale; ce_s = nand_ce_n;
                    io_s = nand_io_out; oe_s = nand_io_oe;
                end
                lowlen++;
            end
            busy++;
            @(negedge clk);
        end
        rv = rd_valid;
        rd = rd_data;
    endtask

    task automatic test_reset();
        chk("R1", "ce_n", nand_ce_n, 4'hF);
        chk("R1", "we_n", nand_we_n, 1);
        chk("R1", "re_n", nand_re_n, 1);
        chk("R1", "cle|ale|oe", nand_cle | nand_ale | nand_io_oe, 0);
        chk("R1", "acc_ready", acc_ready, 1);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "status", status_word, 0);
    endtask

    task automatic test_write(input string tag, input logic [9:0] addr, input logic [7:0] wd,
                              input logic [31:0] wt, input int exp_cle, input int exp_ale,
                              input logic [3:0] exp_ce);
        int busy, setup, lowlen, el;
        logic cle_s, ale_s, oe_s, rv;
        logic [3:0] ce_s;
        logic [7:0] io_s, rd;
        do_access(1'b1, addr, wd, wt, 32'h0, busy, setup, lowlen, cle_s, ale_s, ce_s, io_s, oe_s, rv, rd);
        el = (eff(wt[15:8]) > eff(wt[7:0])) ? eff(wt[15:8]) - eff(wt[7:0]) : 1;
        chk("R3", {tag, " setup"}, setup, eff(wt[31:24]));
        chk("R3", {tag, " we low"}, lowlen, el);
        chk("R3", {tag, " total"}, busy, eff(wt[31:24]) + el + eff(wt[7:0]) + eff(wt[23:16]));
        chk("R3", {tag, " io_out"}, io_s, wd);
        chk("R3", {tag, " io_oe"}, oe_s, 1);
        chk("R2", {tag, " cle"}, cle_s, exp_cle);
        chk("R2", {tag, " ale"}, ale_s, exp_ale);
        chk("R2", {tag, " ce_n"}, ce_s, exp_ce);
        chk("R3", {tag, " no rd_valid"}, rv, 0);
    endtask

    task automatic test_read(input string tag, input logic [9:0] addr, input logic [31:0] wt,
                             input logic [31:0] rt, input logic [3:0] exp_ce);
        int busy, setup, lowlen, lo, t0;
        logic cle_s, ale_s, oe_s, rv;
        logic [3:0] ce_s;
        logic [7:0] io_s, rd;
        do_access(1'b0, addr, 8'h00, wt, rt, busy, setup, lowlen, cle_s, ale_s, ce_s, io_s, oe_s, rv, rd);
        t0 = eff(wt[31:24]);
        lo = (eff(rt[31:24]) > eff(rt[15:8])) ? eff(rt[31:24]) : eff(rt[15:8]);
        chk("R4", {tag, " setup"}, setup, t0);
        chk("R4", {tag, " re low"}, lowlen, lo);
        chk("R4", {tag, " total"}, busy, t0 + lo + eff(rt[23:16]) + eff(rt[7:0]));
        chk("R4", {tag, " rd_valid"}, rv, 1);
        chk("R4", {tag, " rd_data"}, rd, (8'h40 + t0 + eff(rt[31:24]) - 1) & 8'hFF);
        chk("R4", {tag, " io_oe"}, oe_s, 0);
        chk("R2", {tag, " cle|ale"}, cle_s | ale_s, 0);
        chk("R2", {tag, " ce_n"}, ce_s, exp_ce);
        @(negedge clk);
        chk("R4", {tag, " rd_valid single"}, rd_valid, 0);
    endtask

    task automatic test_stall();
        logic prev_we, drop;
        int pulses, accepts, busy_ready;
        logic [7:0] seen [2];
        seen[0] = 0; seen[1] = 0;
        @(negedge clk);
        cfg_wtim = 32'h01000201;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 10'h008; acc_wdata = 8'h11;
        @(posedge clk);
        @(negedge clk);
        acc_wdata = 8'h22;
        accepts = 1; pulses = 0; prev_we = 1'b1; drop = 1'b0; busy_ready = 0;
        for (int i = 0; i < 40; i++) begin
            if (drop) begin acc_valid = 1'b0; drop = 1'b0; end
            if (!nand_we_n && prev_we) begin
                if (pulses < 2) seen[pulses] = nand_io_out;
                pulses++;
            end
            prev_we = nand_we_n;
            if (acc_ready && !(&nand_ce_n)) busy_ready++;
            if (acc_valid && acc_ready) begin accepts++; drop = 1'b1; end
            @(negedge clk);
        end
        chk("R6", "accepts", accepts, 2);
        chk("R6", "write pulses", pulses, 2);
        chk("R6", "first byte", seen[0], 8'h11);
        chk("R6", "stalled byte", seen[1], 8'h22);
        chk("R6", "ready while busy", busy_ready, 0);
    endtask

    task automatic test_ready();
        @(negedge clk); nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "busy bit31", status_word[31], 0);
        nand_rb = 1'b1;
        @(negedge clk);
        chk("R7", "one edge later", status_word[31], 0);
        @(negedge clk);
        chk("R7", "two edges later", status_word[31], 1);
        chk("R7", "low bits", status_word[30:0], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // command byte, chip 0
        test_write("cmd", 10'h000, 8'hA5, 32'h02030602, 1, 0, 4'b1110);
        // address byte, chip 2, cycle shorter than high time
        test_write("adr", 10'h204, 8'h5C, 32'h01010305, 0, 1, 4'b1011);
        // data byte, chip 3, all fields zero (R5)
        test_write("R5 dat", 10'h308, 8'h3C, 32'h00000000, 0, 0, 4'b0111);
        // read, chip 1, pulse longer than access
        test_read("rd1", 10'h108, 32'h03000000, 32'h02020501, 4'b1101);
        // read, access longer than pulse
        test_read("rd2", 10'h108, 32'h01000000, 32'h06010203, 4'b1101);
        // read at command offset, all zero fields (R5)
        test_read("R5 rd0", 10'h000, 32'h0, 32'h0, 4'b1110);
        test_stall();
        test_ready();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule